// File: doc/BRIEF.md
# Clock Output Stop and Park Controller

This block sits between the internal source clocks of a multi-output clock generator and its output buffers. For every output it decides, on each source-clock cycle, whether the output toggles, holds a driven parked level, or floats. The outputs come in five groups. There are CPU differential pairs, SRC differential pairs, single-ended PCI outputs, one DOT differential pair, and single-ended auxiliary fixed-frequency outputs. Each group is gated in the domain of its own source clock.

Several sources can halt an output. The sources are a CPU-group stop pin, a PCI/SRC-group stop pin, a software run bit for the PCI/SRC group, a power-down pin, and two active-low clock-request pins that reach only the SRC pairs selected by a mapping. Register fields choose, per output, whether it is enabled and whether it ignores its group stop. They also choose whether a stopped or powered-down pair parks at a driven level or floats. Each output drives a true level, a complement level, one output enable for each line, and a 2-bit drive-state code.

Every asynchronous control passes through a two-flop synchronizer in the gated clock's domain. Differential pairs change state only on a rising source edge, where a parked pair holds its true line high. Single-ended outputs change state only on a falling edge, where a parked output holds its line low. As a result, no output shows a shortened pulse and every restart begins with a complete cycle.

Top module: `clk_gate_ctrl`

## Requirements
- R1: An output whose `out_en` bit is 0 has drive-state 11 (both enables low, levels 0), whatever the other inputs are.
- R2: With `cpu_stop_n` low and power-down low, a CPU pair whose `free_run` bit is 0 takes state 01 when its `cpu_stop_float` bit is 0 and state 11 when that bit is 1. A CPU pair whose `free_run` bit is 1 stays at 00.
- R3: With `grp_stop_n` low, an SRC pair whose `free_run` bit is 0 takes state 01, or 11 if `src_stop_float` is 1. A PCI output whose `free_run` bit is 0 takes state 01, driven low. Outputs of either kind with `free_run` at 1 keep running.
- R4: `sw_grp_run` at 0 stops the PCI/SRC group exactly as `grp_stop_n` low does. At 1 it has no effect.
- R5: With `pd` high, CPU, SRC and DOT pairs take state 10 (true driven high, complement floating) when their power-down float bit is 0, and 11 when it is 1. PCI and auxiliary outputs take state 01, driven low.
- R6: An SRC pair with its `req_map_a` (or `req_map_b`) bit set takes state 11 while `req_a_n` (or `req_b_n`) is high, and runs while the pin is low. An SRC pair with the mapping bit clear ignores the pin.
- R7: Power-down has priority over the stop pins and the software run bit, and the stops have priority over clock request. So a stopped SRC pair mapped to a deasserted request pin still parks at 01.
- R8: State encoding: 00 running, 01 parked driven, 10 true line driven high with the complement floating, 11 floating. While running, true follows the source clock and a pair's complement is its inverse. In state 01 a pair shows true 1 and complement 0, and a single-ended output shows 0. A floating line reads 0. During reset every output is 11.
- R9: A change on a stop pin shows in a pair's state right after the third rising source edge that follows it, and in a single-ended output's state right after the falling edge that follows the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Source clock of the CPU pairs |
| clk_src | input | 1 | Source clock of the SRC pairs |
| clk_pci | input | 1 | Source clock of the PCI outputs |
| clk_dot | input | 1 | Source clock of the DOT pair |
| clk_aux | input | 1 | Source clock of the auxiliary outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU group |
| grp_stop_n | input | 1 | Active-low stop request for the PCI/SRC group |
| pd | input | 1 | Active-high power-down |
| req_a_n | input | 1 | Clock request A, active low |
| req_b_n | input | 1 | Clock request B, active low |
| sw_grp_run | input | 1 | Software run bit for the PCI/SRC group (0 stops) |
| out_en | input | NOUT | Per-output enable, index order CPU, SRC, PCI, DOT, AUX |
| free_run | input | NOUT | Per-output exemption from the group stop |
| cpu_stop_float | input | N_CPU | Stopped CPU pair floats instead of parking |
| cpu_pd_float | input | N_CPU | CPU pair floats in power-down |
| src_stop_float | input | 1 | Stopped SRC pairs float |
| src_pd_float | input | 1 | SRC pairs float in power-down |
| dot_pd_float | input | 1 | DOT pair floats in power-down |
| req_map_a | input | N_SRC | SRC pairs governed by request A |
| req_map_b | input | N_SRC | SRC pairs governed by request B |
| out_t | output | NOUT | True (or single-ended) level |
| out_c | output | NOUT | Complement level |
| out_oe_t | output | NOUT | Enable of the true line |
| out_oe_c | output | NOUT | Enable of the complement line |
| out_state | output | 2*NOUT | Drive-state code, two bits per output |

## Verification
A wrong stored state appears at once on the level and enable pins. Examples are a stop that fails to clear or a park level picked from the wrong float bit. The bad state shows in the same half cycle as a code that disagrees with the enables, or as a line that stays flat where it should toggle. A wrong synchronizer depth or a wrong update edge moves the first visible change of a stop by one rising edge or by half a cycle. The bench measures that edge exactly. Errors in priority appear only when several sources act together, so power-down, stops and requests are applied in overlapping combinations.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  typedef enum logic [1:0] {
    DS_RUN   = 2'b00,
    DS_PARK  = 2'b01,
    DS_WEAK  = 2'b10,
    DS_FLOAT = 2'b11
  } dstate_e;

  typedef struct packed {
    logic t;
    logic c;
    logic oe_t;
    logic oe_c;
  } pin_t;

  // Priority: disable, then power-down, then group stop, then clock request.
  function automatic dstate_e pick_state(
    input logic en,
    input logic pd_s,
    input logic pd_tri,
    input logic stopped,
    input logic free,
    input logic stop_tri,
    input logic req_off,
    input logic diff
  );
    if (!en)                return DS_FLOAT;
    if (pd_s)               return diff ? (pd_tri ? DS_FLOAT : DS_WEAK) : DS_PARK;
    if (stopped && !free)   return (diff && stop_tri) ? DS_FLOAT : DS_PARK;
    if (req_off)            return DS_FLOAT;
    return DS_RUN;
  endfunction

  function automatic pin_t pin_levels(input dstate_e s, input logic clk_lvl, input logic diff);
    pin_t p;
    unique case (s)
      DS_RUN:  p = '{t: clk_lvl, c: diff & ~clk_lvl, oe_t: 1'b1, oe_c: diff};
      DS_PARK: p = '{t: diff,    c: 1'b0,            oe_t: 1'b1, oe_c: diff};
      DS_WEAK: p = '{t: 1'b1,    c: 1'b0,            oe_t: 1'b1, oe_c: 1'b0};
      default: p = '{t: 1'b0,    c: 1'b0,            oe_t: 1'b0, oe_c: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/clk_gate_sync.sv
module clk_gate_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clk_gate_group.sv
module clk_gate_group
  import clk_gate_pkg::*;
#(
  parameter int N        = 1,
  parameter bit DIFF     = 1'b1,
  parameter bit HAS_STOP = 1'b1,
  parameter bit HAS_REQ  = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_n,
  input  logic           sw_run,
  input  logic           pd,
  input  logic           req_a_n,
  input  logic           req_b_n,
  input  logic [N-1:0]   en,
  input  logic [N-1:0]   free,
  input  logic [N-1:0]   stop_tri,
  input  logic [N-1:0]   pd_tri,
  input  logic [N-1:0]   map_a,
  input  logic [N-1:0]   map_b,
  output logic [N-1:0]   lvl_t,
  output logic [N-1:0]   lvl_c,
  output logic [N-1:0]   oe_t,
  output logic [N-1:0]   oe_c,
  output logic [2*N-1:0] state
);
  // Synchronized controls: [3] stop_n, [2] pd, [1] req_a_n, [0] req_b_n
  localparam logic [3:0] SYNC_IDLE = 4'b1011;

  logic [3:0] ctl_raw, ctl_syn;
  assign ctl_raw = {stop_n, pd, req_a_n, req_b_n};

  clk_gate_sync #(.W(4), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_syn)
  );

  logic grp_stopped, pd_s, req_a_off, req_b_off;
  assign grp_stopped = HAS_STOP && (!ctl_syn[3] || !sw_run);
  assign pd_s        = ctl_syn[2];
  assign req_a_off   = HAS_REQ && ctl_syn[1];
  assign req_b_off   = HAS_REQ && ctl_syn[0];

  for (genvar gi = 0; gi < N; gi++) begin : g_out
    logic    req_off;
    dstate_e nxt, cur;
    pin_t    pins;

    assign req_off = (map_a[gi] && req_a_off) || (map_b[gi] && req_b_off);
    assign nxt = pick_state(en[gi], pd_s, pd_tri[gi], grp_stopped, free[gi],
                            stop_tri[gi], req_off, DIFF);

    if (DIFF) begin : g_rise
      // Pairs park with true high, so switch while the source is high.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= DS_FLOAT;
        else        cur <= nxt;
      end
    end else begin : g_fall
      // Single-ended outputs park low, so switch while the source is low.
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cur <= DS_FLOAT;
        else        cur <= nxt;
      end
    end

    assign pins             = pin_levels(cur, clk, DIFF);
    assign lvl_t[gi]        = pins.t;
    assign lvl_c[gi]        = pins.c;
    assign oe_t[gi]         = pins.oe_t;
    assign oe_c[gi]         = pins.oe_c;
    assign state[2*gi +: 2] = cur;
  end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int N_CPU = 3,
  parameter int N_SRC = 8,
  parameter int N_PCI = 6,
  parameter int N_AUX = 2,
  localparam int NOUT = N_CPU + N_SRC + N_PCI + 1 + N_AUX
) (
  input  logic              clk_cpu,
  input  logic              clk_src,
  input  logic              clk_pci,
  input  logic              clk_dot,
  input  logic              clk_aux,
  input  logic              rst_n,
  input  logic              cpu_stop_n,
  input  logic              grp_stop_n,
  input  logic              pd,
  input  logic              req_a_n,
  input  logic              req_b_n,
  input  logic              sw_grp_run,
  input  logic [NOUT-1:0]   out_en,
  input  logic [NOUT-1:0]   free_run,
  input  logic [N_CPU-1:0]  cpu_stop_float,
  input  logic [N_CPU-1:0]  cpu_pd_float,
  input  logic              src_stop_float,
  input  logic              src_pd_float,
  input  logic              dot_pd_float,
  input  logic [N_SRC-1:0]  req_map_a,
  input  logic [N_SRC-1:0]  req_map_b,
  output logic [NOUT-1:0]   out_t,
  output logic [NOUT-1:0]   out_c,
  output logic [NOUT-1:0]   out_oe_t,
  output logic [NOUT-1:0]   out_oe_c,
  output logic [2*NOUT-1:0] out_state
);
  localparam int O_SRC = N_CPU;
  localparam int O_PCI = O_SRC + N_SRC;
  localparam int O_DOT = O_PCI + N_PCI;
  localparam int O_AUX = O_DOT + 1;

  clk_gate_group #(.N(N_CPU), .DIFF(1'b1), .HAS_STOP(1'b1), .HAS_REQ(1'b0)) u_cpu (
    .clk(clk_cpu), .rst_n(rst_n), .stop_n(cpu_stop_n), .sw_run(1'b1), .pd(pd),
    .req_a_n(1'b1), .req_b_n(1'b1),
    .en(out_en[0 +: N_CPU]), .free(free_run[0 +: N_CPU]),
    .stop_tri(cpu_stop_float), .pd_tri(cpu_pd_float),
    .map_a('0), .map_b('0),
    .lvl_t(out_t[0 +: N_CPU]), .lvl_c(out_c[0 +: N_CPU]),
    .oe_t(out_oe_t[0 +: N_CPU]), .oe_c(out_oe_c[0 +: N_CPU]),
    .state(out_state[0 +: 2*N_CPU])
  );

  clk_gate_group #(.N(N_SRC), .DIFF(1'b1), .HAS_STOP(1'b1), .HAS_REQ(1'b1)) u_src (
    .clk(clk_src), .rst_n(rst_n), .stop_n(grp_stop_n), .sw_run(sw_grp_run), .pd(pd),
    .req_a_n(req_a_n), .req_b_n(req_b_n),
    .en(out_en[O_SRC +: N_SRC]), .free(free_run[O_SRC +: N_SRC]),
    .stop_tri({N_SRC{src_stop_float}}), .pd_tri({N_SRC{src_pd_float}}),
    .map_a(req_map_a), .map_b(req_map_b),
    .lvl_t(out_t[O_SRC +: N_SRC]), .lvl_c(out_c[O_SRC +: N_SRC]),
    .oe_t(out_oe_t[O_SRC +: N_SRC]), .oe_c(out_oe_c[O_SRC +: N_SRC]),
    .state(out_state[2*O_SRC +: 2*N_SRC])
  );

  clk_gate_group #(.N(N_PCI), .DIFF(1'b0), .HAS_STOP(1'b1), .HAS_REQ(1'b0)) u_pci (
    .clk(clk_pci), .rst_n(rst_n), .stop_n(grp_stop_n), .sw_run(sw_grp_run), .pd(pd),
    .req_a_n(1'b1), .req_b_n(1'b1),
    .en(out_en[O_PCI +: N_PCI]), .free(free_run[O_PCI +: N_PCI]),
    .stop_tri('0), .pd_tri('0), .map_a('0), .map_b('0),
    .lvl_t(out_t[O_PCI +: N_PCI]), .lvl_c(out_c[O_PCI +: N_PCI]),
    .oe_t(out_oe_t[O_PCI +: N_PCI]), .oe_c(out_oe_c[O_PCI +: N_PCI]),
    .state(out_state[2*O_PCI +: 2*N_PCI])
  );

  clk_gate_group #(.N(1), .DIFF(1'b1), .HAS_STOP(1'b0), .HAS_REQ(1'b0)) u_dot (
    .clk(clk_dot), .rst_n(rst_n), .stop_n(1'b1), .sw_run(1'b1), .pd(pd),
    .req_a_n(1'b1), .req_b_n(1'b1),
    .en(out_en[O_DOT +: 1]), .free(free_run[O_DOT +: 1]),
    .stop_tri(1'b0), .pd_tri(dot_pd_float), .map_a(1'b0), .map_b(1'b0),
    .lvl_t(out_t[O_DOT +: 1]), .lvl_c(out_c[O_DOT +: 1]),
    .oe_t(out_oe_t[O_DOT +: 1]), .oe_c(out_oe_c[O_DOT +: 1]),
    .state(out_state[2*O_DOT +: 2])
  );

  clk_gate_group #(.N(N_AUX), .DIFF(1'b0), .HAS_STOP(1'b0), .HAS_REQ(1'b0)) u_aux (
    .clk(clk_aux), .rst_n(rst_n), .stop_n(1'b1), .sw_run(1'b1), .pd(pd),
    .req_a_n(1'b1), .req_b_n(1'b1),
    .en(out_en[O_AUX +: N_AUX]), .free(free_run[O_AUX +: N_AUX]),
    .stop_tri('0), .pd_tri('0), .map_a('0), .map_b('0),
    .lvl_t(out_t[O_AUX +: N_AUX]), .lvl_c(out_c[O_AUX +: N_AUX]),
    .oe_t(out_oe_t[O_AUX +: N_AUX]), .oe_c(out_oe_c[O_AUX +: N_AUX]),
    .state(out_state[2*O_AUX +: 2*N_AUX])
  );
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk #(
  parameter int N_CPU = 3,
  parameter int N_SRC = 8,
  parameter int NOUT  = 20
) (
  input logic              clk_cpu,
  input logic              clk_src,
  input logic              rst_n,
  input logic              pd,
  input logic              req_a_n,
  input logic [NOUT-1:0]   out_en,
  input logic [NOUT-1:0]   free_run,
  input logic [N_SRC-1:0]  req_map_a,
  input logic [2*NOUT-1:0] out_state
);
  // Edges seen since reset, saturating at 3 (synchronizer plus state register).
  logic [1:0] age_cpu, age_src;

  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n)              age_cpu <= '0;
    else if (age_cpu != 2'd3) age_cpu <= age_cpu + 2'd1;
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n)              age_src <= '0;
    else if (age_src != 2'd3) age_src <= age_src + 2'd1;
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    a_r1_disabled_floats: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      $past(!out_en[i]) |-> out_state[2*i +: 2] == 2'b11);

    a_r5_pd_not_running: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (age_cpu == 2'd3 && $past(pd, 3) && $past(out_en[i])) |-> out_state[2*i+1]);

    a_r2_free_keeps_running: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (age_cpu == 2'd3 && !$past(pd, 3) && $past(out_en[i]) && $past(free_run[i]))
      |-> out_state[2*i +: 2] == 2'b00);
  end

  for (genvar j = 0; j < N_SRC; j++) begin : g_src
    a_r6_unrequested_not_running: assert property (@(posedge clk_src) disable iff (!rst_n)
      (age_src == 2'd3 && $past(req_map_a[j]) && $past(req_a_n, 3))
      |-> out_state[2*(N_CPU+j) +: 2] != 2'b00);
  end
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.N_CPU(N_CPU), .N_SRC(N_SRC), .NOUT(NOUT)) u_chk (
  .clk_cpu  (clk_cpu),
  .clk_src  (clk_src),
  .rst_n    (rst_n),
  .pd       (pd),
  .req_a_n  (req_a_n),
  .out_en   (out_en),
  .free_run (free_run),
  .req_map_a(req_map_a),
  .out_state(out_state)
);

// File: tb/clk_gate_ctrl_test.sv
`timescale 1ns/1ps
module clk_gate_ctrl_test;
  localparam int N_CPU = 3, N_SRC = 8, N_PCI = 6, N_AUX = 2;
  localparam int NOUT  = N_CPU + N_SRC + N_PCI + 1 + N_AUX;
  localparam int O_SRC = N_CPU, O_PCI = O_SRC + N_SRC, O_DOT = O_PCI + N_PCI;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cpu_stop_n, grp_stop_n, pd, req_a_n, req_b_n, sw_grp_run;
  logic [NOUT-1:0] out_en, free_run;
  logic [N_CPU-1:0] cpu_stop_float, cpu_pd_float;
  logic src_stop_float, src_pd_float, dot_pd_float;
  logic [N_SRC-1:0] req_map_a, req_map_b;
  logic [NOUT-1:0] out_t, out_c, out_oe_t, out_oe_c;
  logic [2*NOUT-1:0] out_state;

  clk_gate_ctrl uut (
    .clk_cpu(clk), .clk_src(clk), .clk_pci(clk), .clk_dot(clk), .clk_aux(clk),
    .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .grp_stop_n(grp_stop_n), .pd(pd),
    .req_a_n(req_a_n), .req_b_n(req_b_n), .sw_grp_run(sw_grp_run),
    .out_en(out_en), .free_run(free_run), .cpu_stop_float(cpu_stop_float),
    .cpu_pd_float(cpu_pd_float), .src_stop_float(src_stop_float),
    .src_pd_float(src_pd_float), .dot_pd_float(dot_pd_float),
    .req_map_a(req_map_a), .req_map_b(req_map_b),
    .out_t(out_t), .out_c(out_c), .out_oe_t(out_oe_t), .out_oe_c(out_oe_c),
    .out_state(out_state)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [2*NOUT-1:0] codes; string tag; } item_t;
  item_t exp_q[$];

  function automatic bit is_pair(int i);
    return (i < O_PCI) || (i == O_DOT);
  endfunction

  // Expected drive state restated from the requirements.
  function automatic logic [1:0] model(int i);
    bit grp_halt = !grp_stop_n || !sw_grp_run;
    if (!out_en[i]) return 2'b11;                                  // R1
    if (pd) begin                                                  // R5, R7
      if (!is_pair(i)) return 2'b01;
      if (i < O_SRC)   return cpu_pd_float[i] ? 2'b11 : 2'b10;
      if (i < O_PCI)   return src_pd_float ? 2'b11 : 2'b10;
      return dot_pd_float ? 2'b11 : 2'b10;
    end
    if (i < O_SRC && !cpu_stop_n && !free_run[i])                  // R2
      return cpu_stop_float[i] ? 2'b11 : 2'b01;
    if (i >= O_SRC && i < O_DOT && grp_halt && !free_run[i])       // R3, R4
      return (i < O_PCI && src_stop_float) ? 2'b11 : 2'b01;
    if (i >= O_SRC && i < O_PCI &&                                 // R6
        ((req_map_a[i-O_SRC] && req_a_n) || (req_map_b[i-O_SRC] && req_b_n)))
      return 2'b11;
    return 2'b00;
  endfunction

  task automatic fail_line(string tag, string what, int i, logic [3:0] act, logic [3:0] exp);
    n_fail++;
    $display("FAIL %s %s out%0d actual=%b expected=%b at %0t", tag, what, i, act, exp, $time);
  endtask

  // Compare one output's code and pins for the current clock phase (R8).
  task automatic check_out(string tag, int i, logic [1:0] code, logic ph);
    logic p = is_pair(i);
    logic [3:0] exp_pins, act_pins;
    case (code)
      2'b00:   exp_pins = {ph, p & ~ph, 1'b1, p};
      2'b01:   exp_pins = {p, 1'b0, 1'b1, p};
      2'b10:   exp_pins = 4'b1010;
      default: exp_pins = 4'b0000;
    endcase
    act_pins = {out_t[i], out_c[i], out_oe_t[i], out_oe_c[i]};
    n_checks++;
    if (out_state[2*i +: 2] !== code)
      fail_line(tag, "state", i, {2'b00, out_state[2*i +: 2]}, {2'b00, code});
    else if (act_pins !== exp_pins)
      fail_line({tag, "/R8"}, "pins t,c,oe_t,oe_c", i, act_pins, exp_pins);
  endtask

  // Monitor: pops each expected item and checks both clock phases.
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      @(posedge clk); #1;
      for (int i = 0; i < NOUT; i++) check_out(exp_q[0].tag, i, exp_q[0].codes[2*i +: 2], 1'b1);
      @(negedge clk); #1;
      for (int i = 0; i < NOUT; i++) check_out(exp_q[0].tag, i, exp_q[0].codes[2*i +: 2], 1'b0);
      void'(exp_q.pop_front());
    end
  end

  // Driver: let the inputs settle through the synchronizers, then push expectations.
  task automatic expect_now(string tag);
    item_t it;
    repeat (5) @(negedge clk);
    for (int i = 0; i < NOUT; i++) it.codes[2*i +: 2] = model(i);
    it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    @(negedge clk); #1;
  endtask

  task automatic check_code(string tag, int i, logic [1:0] exp);
    n_checks++;
    if (out_state[2*i +: 2] !== exp)
      fail_line(tag, "state", i, {2'b00, out_state[2*i +: 2]}, {2'b00, exp});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_stop_n = 1; grp_stop_n = 1; pd = 0; req_a_n = 0; req_b_n = 0;
    sw_grp_run = 1; out_en = '1; free_run = '0; cpu_stop_float = '0; cpu_pd_float = '0;
    src_stop_float = 0; src_pd_float = 0; dot_pd_float = 0; req_map_a = '0; req_map_b = '0;
    repeat (3) @(negedge clk); #1;
    // R8: every output floats during reset
    for (int i = 0; i < NOUT; i++) begin
      check_code("R8 reset", i, 2'b11);
      n_checks++;
      if ({out_oe_t[i], out_oe_c[i]} !== 2'b00)
        fail_line("R8 reset", "oe", i, {2'b00, out_oe_t[i], out_oe_c[i]}, 4'b0000);
    end
    rst_n = 1;
    expect_now("R8 all running");

    out_en[1] = 0; out_en[O_PCI] = 0;
    expect_now("R1 disabled");
    pd = 1;
    expect_now("R1 disabled under power-down");
    pd = 0; out_en = '1;

    cpu_stop_n = 0; free_run[0] = 1; cpu_stop_float = 3'b100;
    expect_now("R2 cpu stop");
    cpu_stop_n = 1; free_run = '0; cpu_stop_float = '0;

    grp_stop_n = 0; free_run[O_SRC] = 1; free_run[O_PCI] = 1;
    expect_now("R3 group stop parked");
    src_stop_float = 1;
    expect_now("R3 group stop floating");
    grp_stop_n = 1;
    expect_now("R4 run bit at 1 no effect");
    sw_grp_run = 0;
    expect_now("R4 software stop");
    sw_grp_run = 1; src_stop_float = 0; free_run = '0;

    pd = 1; cpu_pd_float = 3'b010; dot_pd_float = 1;
    expect_now("R5 power-down");
    cpu_stop_n = 0; grp_stop_n = 0; req_a_n = 1; req_map_a = 8'h0F;
    expect_now("R7 power-down over stops");
    pd = 0; cpu_stop_n = 1; grp_stop_n = 1; cpu_pd_float = '0; dot_pd_float = 0;
    req_a_n = 0; req_map_a = '0;

    req_map_a = 8'b0000_0101; req_map_b = 8'b0000_0010; req_a_n = 1; req_b_n = 0;
    expect_now("R6 request deasserted");
    req_a_n = 0; req_b_n = 1;
    expect_now("R6 request swap");
    grp_stop_n = 0; req_a_n = 1;
    expect_now("R7 stop over request");
    grp_stop_n = 1; req_a_n = 0; req_b_n = 0; req_map_a = '0; req_map_b = '0;
    expect_now("R8 back to running");

    // R9: pair changes right after the third rising edge
    @(negedge clk); #1; cpu_stop_n = 0;
    @(posedge clk); @(posedge clk); #1;
    check_code("R9 pair before third rise", 1, 2'b00);
    @(posedge clk); #1;
    check_code("R9 pair after third rise", 1, 2'b01);
    // R9: single-ended changes at the falling edge after the second rise
    @(negedge clk); #1; grp_stop_n = 0;
    @(posedge clk); @(posedge clk); #1;
    check_code("R9 single before fall", O_PCI + 1, 2'b00);
    @(negedge clk); #1;
    check_code("R9 single after fall", O_PCI + 1, 2'b01);
    cpu_stop_n = 1; grp_stop_n = 1;
    expect_now("R9 restart");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule